// File: doc/BRIEF.md
# Page Translation Buffer with Hardware Table Walk

This block turns 32-bit virtual addresses into physical addresses for a memory system that uses fixed 4 KiB pages. It holds sixteen recently used translations in a fully associative store. A request that finds its page there completes on the next clock. A request whose page is not held starts a hardware walk of a flat, single-level page table in memory. If the fetched table word marks the page as resident, the walk loads it into the store and replays the lookup, which then hits. If the page is not resident, the request ends with a fault flag and the store is left as it was.

The block keeps a use flag and a modified flag for every held page. Any translation sets the use flag. A write to an unmodified page sets the modified flag and also writes the table word back to memory, so the in-memory copy records the modification too. Software can wipe every use flag in one cycle. When a new translation has to be placed, an empty slot is taken first. Failing that, a slot whose use flag is clear is taken. Only when every slot is marked used does a rotating pointer pick the victim.

Top module: `xlat_buffer`

## Requirements
- R1: The physical address returned on completion is the 20-bit physical page number in bits 31..12 with the request's address bits 11..0 unchanged in bits 11..0.
- R2: A read that hits, or a write that hits a page already marked modified, raises `resp_done` in the cycle right after the cycle in which the strobe was accepted, and makes no memory access.
- R3: On a miss the block reads exactly one table word, at address `pt_base + VPN * 4`, where VPN is request bits 31..12.
- R4: A table word has bit 0 = resident, bit 1 = use, bit 2 = modified and bits 31..12 = physical page number. When the word is resident, the translation is loaded, the request completes with its physical address, and a later request to the same page hits with no memory access.
- R5: When the fetched word has bit 0 clear, the request ends with a one-cycle `resp_fault` and no `resp_done`, and no slot is changed. A repeat of that request walks the table again.
- R6: A write that translates through a slot whose modified flag is clear sets that flag. It also writes the word {PPN, nine zero bits, 3'b111} to the same table address before `resp_done`. Later writes to that page cause no memory write.
- R7: While any slot is empty, a new translation goes into the lowest-numbered empty slot, so the first sixteen distinct pages are all kept.
- R8: With every slot full, the victim is the lowest-numbered slot whose use flag is clear.
- R9: With every slot full and every use flag set, a rotating pointer picks the victim. The pointer starts at slot 0 after reset and moves on by one, wrapping, each time it is used.
- R10: A one-cycle `clr_ref` clears every use flag at once, and any later translation through a slot sets its use flag again.
- R11: `req_busy` is high from the cycle after an accepted strobe up to and including the `resp_done` or `resp_fault` cycle. A strobe seen while busy is ignored.
- R12: The modified flag of a loaded translation comes from bit 2 of the fetched word, so a write to a page whose table word already has bit 2 set causes no write-back.
- R13: `mem_req` stays high with `mem_addr` and `mem_we` stable from the start of an access until the cycle in which `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_ref | input | 1 | Clears every use flag in the buffer |
| pt_base | input | 32 | Byte address of page-table word 0 |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | Request is a write |
| req_vaddr | input | 32 | Virtual address |
| req_busy | output | 1 | A request is in flight |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_fault | output | 1 | One-cycle non-resident page pulse |
| resp_paddr | output | 32 | Translated address, valid with resp_done |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Table word address |
| mem_wdata | output | 32 | Table word to write |
| mem_rdata | input | 32 | Table word read, valid with mem_ack |
| mem_ack | input | 1 | Memory completion pulse |

## Verification
The hardest state to reach from the ports is a full buffer in which every use flag is set, or in which only chosen slots are clear. Only there do the rotating pointer and the clear-flag priority decide which page survives. The stimulus first touches sixteen distinct pages to fill every slot. It then adds new pages to drive the pointer around, and pulses `clr_ref` followed by chosen hits to shape the use flags. After that, random traffic over forty pages, with occasional flag clears, keeps the buffer under eviction pressure. A bench model of the slots predicts for each request whether memory is touched.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int VA_W      = 32;
  localparam int PAGE_BITS = 12;
  localparam int PPN_W     = 20;
  localparam int PTE_W     = 32;
  localparam int PTE_SHIFT = 2;
  localparam int VPN_W     = VA_W - PAGE_BITS;
  localparam int PA_W      = PPN_W + PAGE_BITS;
  localparam int PTE_V     = 0;
  localparam int PTE_R     = 1;
  localparam int PTE_D     = 2;
  localparam int PTE_PAD   = PTE_W - PPN_W - 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RETRY, ST_FETCH, ST_WB, ST_DONE, ST_FAULT
  } walk_st_e;

  function automatic logic [VPN_W-1:0] va_vpn(input logic [VA_W-1:0] va);
    return va[VA_W-1:PAGE_BITS];
  endfunction

  function automatic logic [PAGE_BITS-1:0] va_off(input logic [VA_W-1:0] va);
    return va[PAGE_BITS-1:0];
  endfunction

  function automatic logic [VA_W-1:0] pte_addr(input logic [VA_W-1:0] base,
                                               input logic [VPN_W-1:0] vpn);
    return base + (VA_W'(vpn) << PTE_SHIFT);
  endfunction

  function automatic logic [PA_W-1:0] phys_addr(input logic [PPN_W-1:0] ppn,
                                                input logic [PAGE_BITS-1:0] off);
    return {ppn, off};
  endfunction

  function automatic logic [PTE_W-1:0] pte_wb_word(input logic [PPN_W-1:0] ppn);
    return {ppn, {PTE_PAD{1'b0}}, 3'b111};
  endfunction

endpackage

// File: rtl/xlat_cam.sv
module xlat_cam
  import xlat_pkg::*;
#(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] look_vpn,
  output logic [N-1:0]     match_vec,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic [PPN_W-1:0] hit_ppn,
  output logic             hit_dirty,
  input  logic             touch,
  input  logic             touch_wr,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_dirty,
  input  logic             clr_ref,
  output logic [N-1:0]     valid_vec,
  output logic [N-1:0]     ref_vec
);

  logic [N-1:0]     val_q, ref_q, dirty_q;
  logic [VPN_W-1:0] vpn_q [N];
  logic [PPN_W-1:0] ppn_q [N];

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cmp
      assign match_vec[g] = val_q[g] && (vpn_q[g] == look_vpn);
    end
  endgenerate

  always_comb begin
    hit_idx   = '0;
    hit_ppn   = '0;
    hit_dirty = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (match_vec[i]) begin
        hit_idx   = hit_idx | IDX_W'(i);
        hit_ppn   = hit_ppn | ppn_q[i];
        hit_dirty = hit_dirty | dirty_q[i];
      end
    end
  end

  assign hit       = |match_vec;
  assign valid_vec = val_q;
  assign ref_vec   = ref_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q   <= '0;
      ref_q   <= '0;
      dirty_q <= '0;
      for (int i = 0; i < N; i++) begin
        vpn_q[i] <= '0;
        ppn_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (fill_en && (fill_idx == IDX_W'(i))) begin
          val_q[i]   <= 1'b1;
          vpn_q[i]   <= fill_vpn;
          ppn_q[i]   <= fill_ppn;
          dirty_q[i] <= fill_dirty;
          ref_q[i]   <= 1'b0;
        end else if (touch && match_vec[i]) begin
          ref_q[i] <= 1'b1;
          if (touch_wr) dirty_q[i] <= 1'b1;
        end
        if (clr_ref) ref_q[i] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid_vec,
  input  logic [N-1:0]     ref_vec,
  input  logic             advance,
  output logic [IDX_W-1:0] victim_idx,
  output logic             victim_rr
);

  logic [IDX_W-1:0] rr_q, inv_idx, clr_idx;
  logic             inv_found, clr_found;

  always_comb begin
    inv_found = 1'b0;
    clr_found = 1'b0;
    inv_idx   = '0;
    clr_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        inv_found = 1'b1;
        inv_idx   = IDX_W'(i);
      end
      if (valid_vec[i] && !ref_vec[i]) begin
        clr_found = 1'b1;
        clr_idx   = IDX_W'(i);
      end
    end
  end

  assign victim_rr  = !inv_found && !clr_found;
  assign victim_idx = inv_found ? inv_idx : (clr_found ? clr_idx : rr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (advance && victim_rr) begin
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end

endmodule

// File: rtl/xlat_walk.sv
module xlat_walk
  import xlat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VA_W-1:0]  pt_base,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             req_busy,
  output logic             resp_done,
  output logic             resp_fault,
  output logic [PA_W-1:0]  resp_paddr,
  output logic             mem_req,
  output logic             mem_we,
  output logic [VA_W-1:0]  mem_addr,
  output logic [PTE_W-1:0] mem_wdata,
  input  logic [PTE_W-1:0] mem_rdata,
  input  logic             mem_ack,
  output logic [VPN_W-1:0] look_vpn,
  input  logic             look_hit,
  input  logic [PPN_W-1:0] hit_ppn,
  input  logic             hit_dirty,
  output logic             touch,
  output logic             touch_wr,
  output logic             fill_en,
  output logic [VPN_W-1:0] fill_vpn,
  output logic [PPN_W-1:0] fill_ppn,
  output logic             fill_dirty,
  output logic             ev_fast_hit
);

  walk_st_e             st_q, st_d;
  logic [VPN_W-1:0]     vpn_q;
  logic [PAGE_BITS-1:0] off_q;
  logic                 wr_q;
  logic [PA_W-1:0]      pa_q;
  logic                 idle, accept, decide, need_wb;
  logic [PAGE_BITS-1:0] look_off;
  logic                 unused_pte_bits;

  assign idle     = (st_q == ST_IDLE);
  assign accept   = idle && req_valid;
  assign decide   = accept || (st_q == ST_RETRY);
  assign look_vpn = idle ? va_vpn(req_vaddr) : vpn_q;
  assign look_off = idle ? va_off(req_vaddr) : off_q;
  assign touch_wr = idle ? req_write : wr_q;
  assign touch    = decide && look_hit;
  assign need_wb  = touch_wr && !hit_dirty;
  assign ev_fast_hit = accept && look_hit && !need_wb;

  assign fill_en    = (st_q == ST_FETCH) && mem_ack && mem_rdata[PTE_V];
  assign fill_vpn   = vpn_q;
  assign fill_ppn   = mem_rdata[PTE_W-1:PTE_W-PPN_W];
  assign fill_dirty = mem_rdata[PTE_D];
  assign unused_pte_bits = ^{mem_rdata[PTE_W-PPN_W-1:PTE_D+1], mem_rdata[PTE_R]};

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_RETRY: begin
        if (decide) begin
          if (look_hit) st_d = need_wb ? ST_WB : ST_DONE;
          else          st_d = ST_FETCH;
        end
      end
      ST_FETCH: if (mem_ack) st_d = mem_rdata[PTE_V] ? ST_RETRY : ST_FAULT;
      ST_WB:    if (mem_ack) st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      ST_FAULT: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      vpn_q <= '0;
      off_q <= '0;
      wr_q  <= 1'b0;
      pa_q  <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        vpn_q <= va_vpn(req_vaddr);
        off_q <= va_off(req_vaddr);
        wr_q  <= req_write;
      end
      if (touch) pa_q <= phys_addr(hit_ppn, look_off);
    end
  end

  assign req_busy   = !idle;
  assign resp_done  = (st_q == ST_DONE);
  assign resp_fault = (st_q == ST_FAULT);
  assign resp_paddr = pa_q;
  assign mem_req    = (st_q == ST_FETCH) || (st_q == ST_WB);
  assign mem_we     = (st_q == ST_WB);
  assign mem_addr   = pte_addr(pt_base, vpn_q);
  assign mem_wdata  = pte_wb_word(pa_q[PA_W-1:PAGE_BITS]);

endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import xlat_pkg::*;
#(
  parameter int N_ENTRIES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_ref,
  input  logic [31:0] pt_base,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [31:0] req_vaddr,
  output logic        req_busy,
  output logic        resp_done,
  output logic        resp_fault,
  output logic [31:0] resp_paddr,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack
);

  localparam int IDX_W = $clog2(N_ENTRIES);

  logic [VPN_W-1:0]     look_vpn, fill_vpn;
  logic [PPN_W-1:0]     hit_ppn, fill_ppn;
  logic [IDX_W-1:0]     hit_idx, fill_idx;
  logic [N_ENTRIES-1:0] match_vec, valid_vec, ref_vec;
  logic                 look_hit, hit_dirty, touch, touch_wr;
  logic                 fill_en, fill_dirty, ev_fast_hit, victim_rr;

  xlat_walk walk_i (
    .clk, .rst_n, .pt_base, .req_valid, .req_write, .req_vaddr,
    .req_busy, .resp_done, .resp_fault, .resp_paddr,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_ack,
    .look_vpn, .look_hit, .hit_ppn, .hit_dirty, .touch, .touch_wr,
    .fill_en, .fill_vpn, .fill_ppn, .fill_dirty, .ev_fast_hit
  );

  xlat_cam #(.N(N_ENTRIES), .IDX_W(IDX_W)) cam_i (
    .clk, .rst_n, .look_vpn, .match_vec, .hit(look_hit), .hit_idx,
    .hit_ppn, .hit_dirty, .touch, .touch_wr, .fill_en, .fill_idx,
    .fill_vpn, .fill_ppn, .fill_dirty, .clr_ref, .valid_vec, .ref_vec
  );

  xlat_victim #(.N(N_ENTRIES), .IDX_W(IDX_W)) victim_i (
    .clk, .rst_n, .valid_vec, .ref_vec, .advance(fill_en),
    .victim_idx(fill_idx), .victim_rr
  );

endmodule

// File: rtl/xlat_buffer_chk.sv
module xlat_buffer_chk #(
  parameter int N_ENTRIES = 16,
  parameter int IDX_W     = $clog2(N_ENTRIES)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clr_ref,
  input logic                 req_busy,
  input logic                 resp_done,
  input logic                 resp_fault,
  input logic                 mem_req,
  input logic                 mem_we,
  input logic [31:0]          mem_addr,
  input logic [31:0]          mem_rdata,
  input logic                 mem_ack,
  input logic                 ev_fast_hit,
  input logic                 look_hit,
  input logic                 fill_en,
  input logic [IDX_W-1:0]     fill_idx,
  input logic [N_ENTRIES-1:0] match_vec,
  input logic [N_ENTRIES-1:0] valid_vec,
  input logic [N_ENTRIES-1:0] ref_vec
);

  assert_done_fault_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_done && resp_fault));

  assert_fast_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fast_hit |=> resp_done);

  assert_fault_on_absent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack && !mem_rdata[0]) |=> resp_fault);

  assert_mem_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_victim_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !(&valid_vec)) |-> !valid_vec[fill_idx]);

  assert_victim_unused_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && (&valid_vec) && !(&ref_vec)) |-> !ref_vec[fill_idx]);

  assert_retry_hits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> look_hit);

  assert_single_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  assert_clear_use_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ref |=> (ref_vec == '0));

  assert_busy_span_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_done || resp_fault) |-> req_busy);

endmodule

bind xlat_buffer xlat_buffer_chk #(.N_ENTRIES(N_ENTRIES)) chk_i (
  .clk(clk), .rst_n(rst_n), .clr_ref(clr_ref), .req_busy(req_busy),
  .resp_done(resp_done), .resp_fault(resp_fault), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
  .mem_ack(mem_ack), .ev_fast_hit(ev_fast_hit), .look_hit(look_hit),
  .fill_en(fill_en), .fill_idx(fill_idx), .match_vec(match_vec),
  .valid_vec(valid_vec), .ref_vec(ref_vec)
);

// File: tb/xlat_buffer_tb.sv
`timescale 1ns/1ps
module xlat_buffer_tb_top;

  localparam logic [31:0] PT_BASE = 32'h0010_0000;
  localparam int          NSLOT   = 16;
  localparam int          NPAGE   = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_ref = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_busy, resp_done, resp_fault, mem_req, mem_we;
  logic [31:0] resp_paddr, mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  always #2.5 clk = ~clk;

  xlat_buffer dut_i (
    .clk, .rst_n, .clr_ref, .pt_base(PT_BASE), .req_valid, .req_write,
    .req_vaddr, .req_busy, .resp_done, .resp_fault, .resp_paddr,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_ack
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  // page table and memory responder
  logic [31:0] pt [NPAGE];
  int          rd_cnt, wr_cnt, lat;
  logic [31:0] rd_addr, wr_addr, wr_data, cap_addr;
  bit          pend = 1'b0;

  function automatic int word_index(input logic [31:0] a);
    return int'((a - PT_BASE) / 4);
  endfunction

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      pend = 1'b0;
    end else if (mem_req) begin
      if (!pend) begin
        pend = 1'b1;
        cap_addr = mem_addr;
      end else begin
        chk(mem_addr == cap_addr, "R13", "address held while pending", mem_addr, cap_addr);
      end
      if (lat == 0) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          wr_cnt++;
          wr_addr = mem_addr;
          wr_data = mem_wdata;
          if (word_index(mem_addr) < NPAGE) pt[word_index(mem_addr)] = mem_wdata;
        end else begin
          rd_cnt++;
          rd_addr = mem_addr;
          mem_rdata = (word_index(mem_addr) < NPAGE) ? pt[word_index(mem_addr)] : 32'h0;
        end
        lat = $urandom_range(0, 2);
      end else begin
        lat--;
      end
    end
  end

  // reference model of the slots
  bit          m_val [NSLOT];
  bit          m_ref [NSLOT];
  bit          m_dirty [NSLOT];
  int          m_vpn [NSLOT];
  logic [19:0] m_ppn [NSLOT];
  int          m_rr = 0;

  function automatic logic [31:0] expect_pa(input logic [19:0] ppn, input int off);
    return (32'(ppn) * 32'd4096) + 32'(off);
  endfunction

  function automatic logic [31:0] expect_wb(input logic [19:0] ppn);
    return (32'(ppn) << 12) | 32'd7;
  endfunction

  function automatic int choose_slot();
    for (int i = 0; i < NSLOT; i++) if (!m_val[i]) return i;
    for (int i = 0; i < NSLOT; i++) if (!m_ref[i]) return i;
    choose_slot = m_rr;
    m_rr = (m_rr + 1) % NSLOT;
  endfunction

  task automatic pulse_clr();
    @(negedge clk) clr_ref = 1'b1;
    @(negedge clk) clr_ref = 1'b0;
    for (int i = 0; i < NSLOT; i++) m_ref[i] = 1'b0;
  endtask

  // one request; tag names the requirement behind the hit or miss expectation
  task automatic do_req(input int vpn, input int off, input bit wr,
                        input string tag, input bit inject);
    int hi = -1;
    bit e_hit, e_fault = 0, e_wb = 0;
    logic [31:0] e_pa = '0;
    logic [31:0] pte;
    int cyc;
    for (int i = 0; i < NSLOT; i++) if (m_val[i] && m_vpn[i] == vpn) hi = i;
    e_hit = (hi >= 0);
    if (!e_hit) begin
      pte = pt[vpn];
      if (!pte[0]) e_fault = 1;
      else begin
        hi = choose_slot();
        m_val[hi] = 1; m_vpn[hi] = vpn; m_ppn[hi] = pte[31:12];
        m_dirty[hi] = pte[2]; m_ref[hi] = 0;
      end
    end
    if (!e_fault) begin
      m_ref[hi] = 1;
      if (wr && !m_dirty[hi]) begin e_wb = 1; m_dirty[hi] = 1; end
      e_pa = expect_pa(m_ppn[hi], off);
    end
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0;
    req_valid = 1'b1; req_write = wr; req_vaddr = {20'(vpn), 12'(off)};
    @(negedge clk);
    cyc = 1;
    if (inject) begin
      req_vaddr = {20'(vpn + 1), 12'h5a5}; req_write = ~wr;
      chk(req_busy == 1'b1, "R11", "busy during walk", 32'(req_busy), 32'd1);
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    while (!(resp_done || resp_fault) && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc < 300, "R11", "request completes", 32'(cyc), 32'd0);
    chk(resp_fault == e_fault, "R5", "fault flag", 32'(resp_fault), 32'(e_fault));
    chk(resp_done == !e_fault, "R5", "done flag", 32'(resp_done), 32'(!e_fault));
    if (!e_fault) chk(resp_paddr == e_pa, "R1", "physical address", resp_paddr, e_pa);
    chk(rd_cnt == (e_hit ? 0 : 1), tag, "table reads", 32'(rd_cnt), e_hit ? 32'd0 : 32'd1);
    if (!e_hit && rd_cnt == 1)
      chk(rd_addr == PT_BASE + 32'(vpn) * 4, "R3", "walk address", rd_addr, PT_BASE + 32'(vpn) * 4);
    chk(wr_cnt == int'(e_wb), "R6", "write-backs", 32'(wr_cnt), 32'(e_wb));
    if (e_wb && wr_cnt == 1) begin
      chk(wr_addr == PT_BASE + 32'(vpn) * 4, "R6", "write-back address", wr_addr, PT_BASE + 32'(vpn) * 4);
      chk(wr_data == expect_wb(m_ppn[hi]), "R6", "write-back word", wr_data, expect_wb(m_ppn[hi]));
    end
    if (e_hit && !e_wb) chk(cyc == 1, "R2", "hit latency", 32'(cyc), 32'd1);
    if (inject) begin
      repeat (3) begin
        @(negedge clk);
        chk(!resp_done && !resp_fault && !req_busy, "R11", "strobe while busy ignored",
            {29'd0, resp_done, resp_fault, req_busy}, 32'd0);
      end
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "R11", "watchdog expired", 32'd0, 32'd1);
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    lat = 0;
    for (int i = 0; i < NSLOT; i++) begin
      m_val[i] = 0; m_ref[i] = 0; m_dirty[i] = 0; m_vpn[i] = 0; m_ppn[i] = '0;
    end
    for (int i = 0; i < NPAGE; i++) begin
      pt[i] = {20'($urandom), 9'($urandom), 1'b0, 1'($urandom), 1'($urandom_range(0, 9) != 0)};
      if (i < 20) pt[i][0] = 1'b1;
    end
    pt[50] = {20'h0ABCD, 9'd0, 3'b001};
    pt[60] = 32'hFFFF_F006;
    pt[61] = {20'h01234, 9'd0, 3'b101};

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_busy && !resp_done && !resp_fault && !mem_req, "R11", "reset outputs idle",
        {28'd0, req_busy, resp_done, resp_fault, mem_req}, 32'd0);

    for (int v = 0; v < 16; v++) do_req(v, v * 16, 1'b0, "R7", 1'b0);
    for (int v = 0; v < 16; v++) do_req(v, 4095 - v, 1'b0, "R7", 1'b0);

    do_req(16, 1, 1'b0, "R9", 1'b0);
    do_req(1, 2, 1'b0, "R9", 1'b0);
    do_req(0, 3, 1'b0, "R9", 1'b0);
    do_req(1, 4, 1'b0, "R9", 1'b0);
    do_req(16, 5, 1'b0, "R9", 1'b0);

    pulse_clr();
    do_req(5, 6, 1'b0, "R10", 1'b0);
    do_req(17, 7, 1'b0, "R8", 1'b0);
    do_req(18, 8, 1'b0, "R8", 1'b0);
    do_req(5, 9, 1'b0, "R10", 1'b0);

    do_req(61, 10, 1'b1, "R12", 1'b0);
    do_req(61, 11, 1'b1, "R12", 1'b0);

    do_req(50, 12, 1'b0, "R11", 1'b1);
    do_req(50, 13, 1'b1, "R6", 1'b0);
    do_req(50, 14, 1'b1, "R6", 1'b0);
    do_req(50, 15, 1'b0, "R4", 1'b0);

    do_req(60, 16, 1'b0, "R5", 1'b0);
    do_req(60, 17, 1'b1, "R5", 1'b0);

    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 19) == 0) pulse_clr();
      do_req($urandom_range(0, 39), $urandom_range(0, 4095), $urandom_range(0, 3) == 0, "R4", 1'b0);
    end

    repeat (4) @(negedge clk);
    summary();
  end

endmodule